// File: doc/BRIEF.md
# Chroma Format Classifier and MCU Mapper

This block turns the per-component sampling factors of a compressed image, its component count and its picture size into the setup values a downstream block decoder needs. The six 4-bit factors are packed into a 24-bit layout code. The code is matched against seven supported chroma layouts, which selects a planar output format and a flag that halves chroma width. Any other code is reported as an error.

From the luma factors and the picture size the block derives the MCU grid, the MCU total and the count of 8x8 units. It also produces a compact per-component factor word. A small state machine then walks the block slots of one MCU, one slot per clock, and tags each slot with the component that owns it. Single-component images get a fixed grayscale membership pattern instead.

A one-cycle `start` latches all inputs. The block is busy for exactly one cycle per slot and then pulses `done`. Every result holds steady until the next accepted start.

Top module: `fmt_mcu_mapper`

## Requirements
- R1: `fmt_code` equals {hfac_y, vfac_y, hfac_u, vfac_u, hfac_v, vfac_v}, one nibble each with hfac_y in bits 23:20, as latched at the last accepted start.
- R2: `fmt_err` is 1 exactly when `fmt_code` is none of 0x221111, 0x211111, 0x111111, 0x121111, 0x412121, 0x222121, 0x110000. On an error `out_fmt` is 0 and `cshrink` is 0.
- R3: `out_fmt` uses 0 = none, 1 = grey, 2 = planar 4:2:0, 3 = planar 4:2:2. 0x111111 gives 3 with `cshrink`=1. 0x211111 and 0x412121 give 3 with `cshrink`=0. 0x121111 and 0x222121 give 2 with `cshrink`=1. 0x221111 gives 2 with `cshrink`=0. 0x110000 gives 1 with `cshrink`=0.
- R4: `mcu_cols` = ceil(pic_w / 2^(2+hfac_y)), `mcu_rows` = ceil(pic_h / 2^(2+vfac_y)), and `mcu_total` = mcu_cols * mcu_rows.
- R5: `unit_total` = ceil(pic_w/8) * ceil(pic_h/8).
- R6: For `ncomp` other than 1, `memb_word[29:0]` holds 10 slots of 3 bits, slot i in bits 3i+2:3i. Component c owns hfac*vfac slots, and the quotas are laid out in component order. A slot below the sum of quotas of components below `ncomp` holds 4+c. Every later slot holds 7. Bit 31 is 0 and bit 30 is 1.
- R7: For `ncomp` = 1, `memb_word` is 0xFFFFFFFC: bit 31 (grayscale) = 1, bit 30 = 1, and slot 0 = 4 with all other slots 7.
- R8: `samp_word` packs ((h-1)&3)<<2 | ((v-1)&3) per component, Y in bits 11:8, U in 7:4, V in 3:0. It is 0 when `ncomp` = 1.
- R9: A `start` sampled high while `busy` is 0 raises `busy` at that edge. `busy` stays high for 10 cycles. `done` is high for exactly the one cycle after `busy` falls, and `busy` is 0 while `done` is high.
- R10: A `start` while `busy` is 1 is ignored. Input changes without an accepted start do not change any output.
- R11: After reset, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latch inputs and begin a mapping run |
| ncomp | input | 2 | Number of image components |
| hfac_y | input | 4 | Horizontal sampling factor, component 0 |
| vfac_y | input | 4 | Vertical sampling factor, component 0 |
| hfac_u | input | 4 | Horizontal sampling factor, component 1 |
| vfac_u | input | 4 | Vertical sampling factor, component 1 |
| hfac_v | input | 4 | Horizontal sampling factor, component 2 |
| vfac_v | input | 4 | Vertical sampling factor, component 2 |
| pic_w | input | 16 | Picture width in pixels |
| pic_h | input | 16 | Picture height in pixels |
| busy | output | 1 | Membership walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fmt_code | output | 24 | Packed layout code |
| fmt_err | output | 1 | Unsupported layout |
| out_fmt | output | 2 | Selected output planar format |
| cshrink | output | 1 | Chroma horizontal halving flag |
| mcu_cols | output | 16 | MCU columns |
| mcu_rows | output | 16 | MCU rows |
| mcu_total | output | 32 | MCU count |
| unit_total | output | 32 | 8x8 unit count |
| samp_word | output | 12 | Packed factor-minus-one word |
| memb_word | output | 32 | Slot membership word with control bits |

## Verification
The checker watches the handshake on every cycle: the length of the walk, the single-cycle done pulse, and refusal of a start while busy. It also checks that outputs hold while idle, that an error forces the "none" format, and that the grayscale flag always comes with the fixed pattern and a zero factor word. The arithmetic values (layout mapping, MCU and unit counts at the 16-bit edges, and slot assignment when the quotas overflow the ten slots) can only be shown by the bench's directed layouts, which compare against values computed from the requirements.

// File: rtl/fmt_mcu_pkg.sv
package fmt_mcu_pkg;

  // output planar format encoding, visible on out_fmt
  typedef enum logic [1:0] {
    OFMT_NONE   = 2'd0,
    OFMT_GREY   = 2'd1,
    OFMT_YUV420 = 2'd2,
    OFMT_YUV422 = 2'd3
  } ofmt_e;

  // recognised packed layout codes
  localparam logic [23:0] LAY_SUB420   = 24'h221111;
  localparam logic [23:0] LAY_SUB422   = 24'h211111;
  localparam logic [23:0] LAY_FULL444  = 24'h111111;
  localparam logic [23:0] LAY_SUB422V  = 24'h121111;
  localparam logic [23:0] LAY_WIDE422  = 24'h412121;
  localparam logic [23:0] LAY_WIDE422V = 24'h222121;
  localparam logic [23:0] LAY_MONO     = 24'h110000;

  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_RUN  = 1'b1
  } walk_st_e;

endpackage

// File: rtl/fmm_rst_sync.sv
module fmm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  // assert at once, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/fmt_classifier.sv
module fmt_classifier
  import fmt_mcu_pkg::*;
(
  input  logic [23:0] code,
  output ofmt_e       fmt,
  output logic        shrink,
  output logic        err
);

  always_comb begin
    fmt    = OFMT_NONE;
    shrink = 1'b0;
    err    = 1'b0;
    case (code)
      LAY_FULL444: begin
        fmt    = OFMT_YUV422;
        shrink = 1'b1;
      end
      LAY_SUB422, LAY_WIDE422: begin
        fmt    = OFMT_YUV422;
      end
      LAY_SUB422V, LAY_WIDE422V: begin
        fmt    = OFMT_YUV420;
        shrink = 1'b1;
      end
      LAY_SUB420: begin
        fmt    = OFMT_YUV420;
      end
      LAY_MONO: begin
        fmt    = OFMT_GREY;
      end
      default: begin
        err    = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/mcu_geometry.sv
module mcu_geometry #(
  parameter int DIM_W = 16,
  parameter int FAC_W = 4
) (
  input  logic [DIM_W-1:0]   pic_w,
  input  logic [DIM_W-1:0]   pic_h,
  input  logic [FAC_W-1:0]   hfac,
  input  logic [FAC_W-1:0]   vfac,
  output logic [DIM_W-1:0]   cols,
  output logic [DIM_W-1:0]   rows,
  output logic [2*DIM_W-1:0] total,
  output logic [2*DIM_W-1:0] units
);

  // wide enough for pic + 2^(2+max factor)
  localparam int EXT_W = DIM_W + (1 << FAC_W) + 3;
  localparam int CNT_W = 2 * DIM_W;

  logic [FAC_W:0]   sh_w, sh_h;
  logic [EXT_W-1:0] span_w, span_h;
  logic [EXT_W-1:0] cols_ext, rows_ext;
  logic [DIM_W:0]   ucol, urow;

  always_comb begin
    sh_w     = {1'b0, hfac} + (FAC_W+1)'(2);
    sh_h     = {1'b0, vfac} + (FAC_W+1)'(2);
    span_w   = EXT_W'(1) << sh_w;
    span_h   = EXT_W'(1) << sh_h;
    cols_ext = (EXT_W'(pic_w) + span_w - EXT_W'(1)) >> sh_w;
    rows_ext = (EXT_W'(pic_h) + span_h - EXT_W'(1)) >> sh_h;
  end

  assign cols  = cols_ext[DIM_W-1:0];
  assign rows  = rows_ext[DIM_W-1:0];
  assign total = CNT_W'(cols) * CNT_W'(rows);

  always_comb begin
    ucol = ({1'b0, pic_w} + (DIM_W+1)'(7)) >> 3;
    urow = ({1'b0, pic_h} + (DIM_W+1)'(7)) >> 3;
  end

  assign units = CNT_W'(ucol) * CNT_W'(urow);

endmodule

// File: rtl/memb_walker.sv
module memb_walker
  import fmt_mcu_pkg::*;
#(
  parameter int SLOTS = 10,
  parameter int QW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic [1:0]            ncomp,
  input  logic [3:0][QW-1:0]    quota,
  input  logic [QW+1:0]         blk_total,
  output logic                  busy,
  output logic                  done,
  output logic [3*SLOTS-1:0]    slots
);

  localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int TOT_W  = QW + 2;
  localparam int SLOT_B = 3 * SLOTS;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

  walk_st_e          st_q, st_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [1:0]        comp_q, comp_n;
  logic [QW-1:0]     blk_q, blk_n;
  logic [SLOT_B-1:0] slots_q, slots_n;
  logic              done_q, done_n;
  logic [QW-1:0]     blk_inc;
  logic [2:0]        slot_val;
  logic              slot_used;

  // next-state process
  always_comb begin
    st_n      = st_q;
    idx_n     = idx_q;
    comp_n    = comp_q;
    blk_n     = blk_q;
    slots_n   = slots_q;
    done_n    = 1'b0;
    blk_inc   = blk_q + QW'(1);
    slot_used = (TOT_W'(idx_q) < blk_total) && (comp_q < ncomp);
    slot_val  = 3'b111;
    case (st_q)
      WK_IDLE: begin
        if (go) begin
          st_n    = WK_RUN;
          idx_n   = '0;
          comp_n  = '0;
          blk_n   = '0;
          slots_n = '1;
        end
      end
      WK_RUN: begin
        if (slot_used) begin
          slot_val = {1'b1, comp_q};
          if (blk_inc == quota[comp_q]) begin
            comp_n = comp_q + 2'd1;
            blk_n  = '0;
          end else begin
            blk_n  = blk_inc;
          end
        end
        slots_n[3*int'(idx_q) +: 3] = slot_val;
        if (idx_q == LAST_IDX) begin
          st_n   = WK_IDLE;
          done_n = 1'b1;
        end else begin
          idx_n  = idx_q + IDX_W'(1);
        end
      end
      default: begin
        st_n = WK_IDLE;
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WK_IDLE;
      idx_q   <= '0;
      comp_q  <= '0;
      blk_q   <= '0;
      slots_q <= '1;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      idx_q   <= idx_n;
      comp_q  <= comp_n;
      blk_q   <= blk_n;
      slots_q <= slots_n;
      done_q  <= done_n;
    end
  end

  assign busy  = (st_q == WK_RUN);
  assign done  = done_q;
  assign slots = slots_q;

endmodule

// File: rtl/fmt_mcu_mapper.sv
module fmt_mcu_mapper
  import fmt_mcu_pkg::*;
#(
  parameter int DIM_W = 16,
  parameter int FAC_W = 4,
  parameter int SLOTS = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [1:0]             ncomp,
  input  logic [FAC_W-1:0]       hfac_y,
  input  logic [FAC_W-1:0]       vfac_y,
  input  logic [FAC_W-1:0]       hfac_u,
  input  logic [FAC_W-1:0]       vfac_u,
  input  logic [FAC_W-1:0]       hfac_v,
  input  logic [FAC_W-1:0]       vfac_v,
  input  logic [DIM_W-1:0]       pic_w,
  input  logic [DIM_W-1:0]       pic_h,
  output logic                   busy,
  output logic                   done,
  output logic [6*FAC_W-1:0]     fmt_code,
  output logic                   fmt_err,
  output logic [1:0]             out_fmt,
  output logic                   cshrink,
  output logic [DIM_W-1:0]       mcu_cols,
  output logic [DIM_W-1:0]       mcu_rows,
  output logic [2*DIM_W-1:0]     mcu_total,
  output logic [2*DIM_W-1:0]     unit_total,
  output logic [11:0]            samp_word,
  output logic [3*SLOTS+1:0]     memb_word
);

  localparam int NCOMP_MAX = 3;
  localparam int QW        = 2 * FAC_W;
  localparam int TOT_W     = QW + 2;
  localparam int SLOT_B    = 3 * SLOTS;
  localparam logic [SLOT_B-1:0] MONO_SLOTS = {{(SLOTS-1){3'b111}}, 3'b100};

  logic rst_n_sync;

  fmm_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // latched configuration
  logic [1:0]                          ncomp_q, ncomp_n;
  logic [NCOMP_MAX-1:0][FAC_W-1:0]     hf_q, hf_n, vf_q, vf_n;
  logic [DIM_W-1:0]                    pw_q, pw_n, ph_q, ph_n;
  logic                                take;

  assign take = start & ~busy;

  always_comb begin
    ncomp_n = ncomp_q;
    hf_n    = hf_q;
    vf_n    = vf_q;
    pw_n    = pw_q;
    ph_n    = ph_q;
    if (take) begin
      ncomp_n = ncomp;
      hf_n    = {hfac_v, hfac_u, hfac_y};
      vf_n    = {vfac_v, vfac_u, vfac_y};
      pw_n    = pic_w;
      ph_n    = pic_h;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      ncomp_q <= '0;
      hf_q    <= '0;
      vf_q    <= '0;
      pw_q    <= '0;
      ph_q    <= '0;
    end else begin
      ncomp_q <= ncomp_n;
      hf_q    <= hf_n;
      vf_q    <= vf_n;
      pw_q    <= pw_n;
      ph_q    <= ph_n;
    end
  end

  // layout code and classification
  assign fmt_code = {hf_q[0], vf_q[0], hf_q[1], vf_q[1], hf_q[2], vf_q[2]};

  ofmt_e cls_fmt;

  fmt_classifier u_cls (
    .code   (fmt_code),
    .fmt    (cls_fmt),
    .shrink (cshrink),
    .err    (fmt_err)
  );

  assign out_fmt = cls_fmt;

  // MCU grid
  mcu_geometry #(
    .DIM_W (DIM_W),
    .FAC_W (FAC_W)
  ) u_geo (
    .pic_w (pw_q),
    .pic_h (ph_q),
    .hfac  (hf_q[0]),
    .vfac  (vf_q[0]),
    .cols  (mcu_cols),
    .rows  (mcu_rows),
    .total (mcu_total),
    .units (unit_total)
  );

  // per-component quotas and factor nibbles
  logic [3:0][QW-1:0]         quota;
  logic [NCOMP_MAX-1:0][3:0]  nib;
  logic [TOT_W-1:0]           blk_total;

  for (genvar g = 0; g < NCOMP_MAX; g++) begin : g_comp
    logic [FAC_W-1:0] hm1, vm1;
    assign quota[g] = QW'(hf_q[g]) * QW'(vf_q[g]);
    assign hm1      = hf_q[g] - FAC_W'(1);
    assign vm1      = vf_q[g] - FAC_W'(1);
    assign nib[g]   = {hm1[1:0], vm1[1:0]};
  end
  assign quota[3] = '0;

  always_comb begin
    blk_total = '0;
    for (int i = 0; i < NCOMP_MAX; i++) begin
      if (2'(i) < ncomp_q) begin
        blk_total = blk_total + TOT_W'(quota[i]);
      end
    end
  end

  logic mono;
  assign mono      = (ncomp_q == 2'd1);
  assign samp_word = mono ? 12'h000 : {nib[0], nib[1], nib[2]};

  // membership walk
  logic [SLOT_B-1:0] walk_slots;

  memb_walker #(
    .SLOTS (SLOTS),
    .QW    (QW)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .go        (take),
    .ncomp     (ncomp_q),
    .quota     (quota),
    .blk_total (blk_total),
    .busy      (busy),
    .done      (done),
    .slots     (walk_slots)
  );

  assign memb_word = {mono, 1'b1, (mono ? MONO_SLOTS : walk_slots)};

endmodule

// File: rtl/fmt_mcu_mapper_chk.sv
module fmt_mcu_mapper_chk #(
  parameter int DIM_W = 16,
  parameter int FAC_W = 4,
  parameter int SLOTS = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic [6*FAC_W-1:0]   fmt_code,
  input logic                 fmt_err,
  input logic [1:0]           out_fmt,
  input logic                 cshrink,
  input logic [2*DIM_W-1:0]   mcu_total,
  input logic [2*DIM_W-1:0]   unit_total,
  input logic [11:0]          samp_word,
  input logic [3*SLOTS+1:0]   memb_word
);

  localparam int CW = $clog2(SLOTS + 2);
  localparam logic [3*SLOTS-1:0] MONO_PAT = {{(SLOTS-1){3'b111}}, 3'b100};

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (busy) begin
      run_cnt <= run_cnt + CW'(1);
    end else begin
      run_cnt <= '0;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R9
  walk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == CW'(SLOTS)));

  // R2
  err_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> (out_fmt == 2'd0 && !cshrink));

  // R3
  shrink_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cshrink |-> (out_fmt == 2'd2 || out_fmt == 2'd3));

  // R7
  mono_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memb_word[3*SLOTS+1] |-> (memb_word[3*SLOTS-1:0] == MONO_PAT && samp_word == 12'h000));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(fmt_code) && $stable(mcu_total) && $stable(unit_total)
                           && $stable(memb_word) && $stable(samp_word) && $stable(out_fmt)));

endmodule

bind fmt_mcu_mapper fmt_mcu_mapper_chk #(
  .DIM_W (DIM_W),
  .FAC_W (FAC_W),
  .SLOTS (SLOTS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_sync),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .fmt_code   (fmt_code),
  .fmt_err    (fmt_err),
  .out_fmt    (out_fmt),
  .cshrink    (cshrink),
  .mcu_total  (mcu_total),
  .unit_total (unit_total),
  .samp_word  (samp_word),
  .memb_word  (memb_word)
);

// File: tb/fmt_mcu_mapper_tb.sv
module fmt_mcu_mapper_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SLOTS      = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  ncomp;
  logic [3:0]  hfac_y, vfac_y, hfac_u, vfac_u, hfac_v, vfac_v;
  logic [15:0] pic_w, pic_h;
  logic        busy, done, fmt_err, cshrink;
  logic [23:0] fmt_code;
  logic [1:0]  out_fmt;
  logic [15:0] mcu_cols, mcu_rows;
  logic [31:0] mcu_total, unit_total;
  logic [11:0] samp_word;
  logic [31:0] memb_word;

  int checks = 0;
  int errors = 0;

  // model inputs of the last accepted start
  int m_nc, m_w, m_h;
  int m_f[6];

  always #(CLK_PERIOD/2) clk = ~clk;

  fmt_mcu_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ncomp(ncomp),
    .hfac_y(hfac_y), .vfac_y(vfac_y), .hfac_u(hfac_u), .vfac_u(vfac_u),
    .hfac_v(hfac_v), .vfac_v(vfac_v), .pic_w(pic_w), .pic_h(pic_h),
    .busy(busy), .done(done), .fmt_code(fmt_code), .fmt_err(fmt_err),
    .out_fmt(out_fmt), .cshrink(cshrink), .mcu_cols(mcu_cols), .mcu_rows(mcu_rows),
    .mcu_total(mcu_total), .unit_total(unit_total), .samp_word(samp_word),
    .memb_word(memb_word)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(int nc, int f0, int f1, int f2, int f3, int f4, int f5, int w, int h);
    ncomp  = 2'(nc);
    hfac_y = 4'(f0); vfac_y = 4'(f1);
    hfac_u = 4'(f2); vfac_u = 4'(f3);
    hfac_v = 4'(f4); vfac_v = 4'(f5);
    pic_w  = 16'(w); pic_h = 16'(h);
  endtask

  task automatic apply(int nc, int f0, int f1, int f2, int f3, int f4, int f5, int w, int h);
    m_nc = nc; m_w = w; m_h = h;
    m_f[0] = f0; m_f[1] = f1; m_f[2] = f2; m_f[3] = f3; m_f[4] = f4; m_f[5] = f5;
    drive(nc, f0, f1, f2, f3, f4, f5, w, h);
  endtask

  // pulse start and check the walk timing; optional start poke mid-walk
  task automatic walk(bit poke);
    bit ok = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= SLOTS; k++) begin
      if (!busy || done) ok = 1'b0;
      if (poke && k == 3) begin
        drive(2, 3, 3, 2, 2, 1, 1, 4000, 4000);
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    if (!done || busy) ok = 1'b0;
    @(negedge clk);
    if (done) ok = 1'b0;
    chk("R9", "walk timing and done pulse", longint'(ok), 1);
  endtask

  task automatic check_all();
    int code, s0, s1, cols, rows, tot;
    int efmt, eshr, eerr;
    int q[3];
    int comp, blk;
    logic [29:0] slots;
    logic [11:0] esamp;
    code = (m_f[0] << 20) | (m_f[1] << 16) | (m_f[2] << 12) | (m_f[3] << 8) | (m_f[4] << 4) | m_f[5];
    chk("R1", "fmt_code", longint'(fmt_code), longint'(code));
    efmt = 0; eshr = 0; eerr = 0;
    case (code)
      'h111111: begin efmt = 3; eshr = 1; end
      'h211111, 'h412121: efmt = 3;
      'h121111, 'h222121: begin efmt = 2; eshr = 1; end
      'h221111: efmt = 2;
      'h110000: efmt = 1;
      default: eerr = 1;
    endcase
    chk("R2", "fmt_err", longint'(fmt_err), longint'(eerr));
    chk("R3", "out_fmt/cshrink", longint'({out_fmt, cshrink}), longint'(efmt * 2 + eshr));
    s0 = 2 + m_f[0]; s1 = 2 + m_f[1];
    cols = (m_w + (1 << s0) - 1) >> s0;
    rows = (m_h + (1 << s1) - 1) >> s1;
    chk("R4", "mcu_cols", longint'(mcu_cols), longint'(cols));
    chk("R4", "mcu_rows", longint'(mcu_rows), longint'(rows));
    chk("R4", "mcu_total", longint'(mcu_total), longint'(cols) * longint'(rows));
    chk("R5", "unit_total", longint'(unit_total),
        longint'((m_w + 7) >> 3) * longint'((m_h + 7) >> 3));
    for (int i = 0; i < 3; i++) q[i] = m_f[2*i] * m_f[2*i+1];
    tot = 0;
    for (int i = 0; i < 3; i++) if (i < m_nc) tot += q[i];
    comp = 0; blk = 0;
    for (int i = 0; i < SLOTS; i++) begin
      if (i < tot && comp < m_nc) begin
        slots[3*i +: 3] = 3'(4 + comp);
        blk++;
        if (blk == q[comp]) begin comp++; blk = 0; end
      end else begin
        slots[3*i +: 3] = 3'b111;
      end
    end
    if (m_nc == 1) begin
      chk("R7", "grey memb_word", longint'(memb_word), longint'(32'hFFFF_FFFC));
      esamp = 12'h000;
    end else begin
      chk("R6", "memb_word", longint'(memb_word), longint'({2'b01, slots}));
      for (int i = 0; i < 3; i++)
        esamp[4*(2-i) +: 4] = {2'(m_f[2*i] - 1), 2'(m_f[2*i+1] - 1)};
    end
    chk("R8", "samp_word", longint'(samp_word), longint'(esamp));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R11", "busy after reset", longint'(busy), 0);
    chk("R11", "done after reset", longint'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_case(int nc, int f0, int f1, int f2, int f3, int f4, int f5, int w, int h);
    @(negedge clk);
    apply(nc, f0, f1, f2, f3, f4, f5, w, h);
    walk(1'b0);
    check_all();
  endtask

  // R10: start during the walk has no effect
  task automatic t_ignore();
    @(negedge clk);
    apply(3, 2, 2, 1, 1, 1, 1, 200, 120);
    walk(1'b1);
    start = 1'b0;
    chk("R10", "code kept after mid-walk start", longint'(fmt_code), longint'(24'h221111));
    check_all();
  endtask

  // R10: input changes without start leave outputs alone
  task automatic t_hold();
    logic [31:0] s_memb, s_tot, s_unit;
    logic [23:0] s_code;
    s_memb = memb_word; s_tot = mcu_total; s_unit = unit_total; s_code = fmt_code;
    drive(1, 1, 1, 0, 0, 0, 0, 9999, 77);
    repeat (6) @(negedge clk);
    chk("R10", "memb_word held", longint'(memb_word), longint'(s_memb));
    chk("R10", "mcu_total held", longint'(mcu_total), longint'(s_tot));
    chk("R10", "unit_total held", longint'(unit_total), longint'(s_unit));
    chk("R10", "fmt_code held", longint'(fmt_code), longint'(s_code));
    chk("R10", "busy stays low", longint'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_case(3, 2, 2, 1, 1, 1, 1, 1920, 1080);   // 4:2:0
    t_case(3, 2, 1, 1, 1, 1, 1, 640, 480);     // 4:2:2
    t_case(3, 1, 1, 1, 1, 1, 1, 100, 75);      // 4:4:4
    t_case(3, 1, 2, 1, 1, 1, 1, 33, 17);       // vertical 4:2:2
    t_case(3, 4, 1, 2, 1, 2, 1, 1000, 9);      // wide 4:2:2
    t_case(3, 2, 2, 2, 1, 2, 1, 65535, 65535); // wide vertical, max size
    t_case(1, 1, 1, 0, 0, 0, 0, 8, 8);         // grey
    t_case(3, 3, 3, 1, 1, 1, 1, 50, 50);       // unsupported, quotas overflow slots
    t_case(2, 2, 2, 1, 1, 1, 1, 1, 1);         // two components, minimum size
    t_ignore();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule